// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block turns one write of a control byte into a short master burst on an I2C bus. The burst moves one to four bytes to or from a slave at a 7-bit address. It does not drive SCL or SDA. Instead it hands whole commands (start with address, send a byte, receive a byte, stop) to a byte-level bus agent, waits for that agent to acknowledge each one, and reads back whether the slave acknowledged. When the burst ends, the sequencer records how many bytes completed, updates the error and abort flags, fills the receive lanes on a read, and can raise an interrupt.

The control byte selects the direction, the byte count, and what happens to the bus between bytes. The bus can be released after every byte. It can also be held across bytes and across bursts, so that a later burst continues without a new address phase. A separate halt request frees a held bus by issuing a stop. The control byte's own bit layout, which software uses to encode requests, is part of the behaviour: bit 0 start, bit 1 read, bit 2 hold bus (chain), bit 3 stop after every byte, bits 5:4 byte count minus one, bit 6 ten-bit request (ignored), bit 7 halt.

Top module: `i2cseq_top`

## Requirements
- R1: After a synchronous active-low reset, the outputs read as follows: ctrl_q is 0, xfer_count is 0, buf_idx is 3'b111, err, aborted, rx_nonempty, rx_full, irq, busy and bus_req are all 0, and the bus is treated as not held.
- R2: If busy is low, a control write stores the written byte in ctrl_q with bit 0 cleared. If busy is high, the write is dropped completely: ctrl_q does not change and no new burst or halt starts.
- R3: The slave address sent with every start command is mst_addr[7:1]. Setting bit 6 of the control byte changes neither the address nor the sequence.
- R4: Each byte begins with a start command (bus_cmd 0) only when the bus is not held. If the slave nacks the address, err and aborted are set and the burst ends at once. If the slave acks the address, err is cleared.
- R5: If the slave nacks a data command (send 1, receive 2), err and aborted are set and the burst ends without a stop. The nacked byte does not count as completed.
- R6: After each completed byte, a stop command (bus_cmd 3) is issued if bit 3 is set or bit 2 is clear. Otherwise the bus stays held and the next byte or burst skips the address phase.
- R7: When a burst ends, xfer_count holds the number of completed bytes and buf_idx holds that number minus one, modulo 8.
- R8: In a read burst, byte i is stored in rx_bytes[8i+7:8i]. Write bursts send tx_bytes[8i+7:8i] as byte i. At the end of a read burst, rx_nonempty is set if at least one byte completed, and rx_full is set if four bytes completed. Both flags stay set.
- R9: A control write with bit 7 set while the bus is held issues one stop and no transfer, even if bit 0 is also set. When that stop is acknowledged, irq is raised if int_en and mask_halt are both high.
- R10: At the end of a burst, irq is raised if at least one byte completed and int_en and mask_done are both high.
- R11: bus_req remains high, and bus_cmd and bus_wdata remain unchanged, until the cycle in which bus_ack is high. A command is finished in that cycle.
- R12: A pulse on irq_ack clears irq. A new interrupt event in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte value |
| mst_addr | input | 8 | Address register; bits 7:1 are the slave address |
| tx_bytes | input | 32 | Bytes to send, byte i in lane i |
| int_en | input | 1 | Global interrupt enable |
| mask_done | input | 1 | Enables the completion interrupt |
| mask_halt | input | 1 | Enables the halt interrupt |
| irq_ack | input | 1 | Clears the interrupt |
| bus_req | output | 1 | Command request to the bus agent |
| bus_cmd | output | 2 | 0 start, 1 send, 2 receive, 3 stop |
| bus_addr | output | 7 | Slave address for start |
| bus_read | output | 1 | Direction for start |
| bus_wdata | output | 8 | Byte for send |
| bus_ack | input | 1 | Agent finished the current command |
| bus_nack | input | 1 | Slave did not acknowledge (valid with bus_ack) |
| bus_rdata | input | 8 | Received byte (valid with bus_ack) |
| ctrl_q | output | 8 | Stored control byte |
| xfer_count | output | 3 | Completed bytes of the last burst |
| buf_idx | output | 3 | Completed bytes minus one |
| rx_bytes | output | 32 | Received bytes, byte i in lane i |
| err | output | 1 | Error status |
| aborted | output | 1 | Transfer-aborted flag (sticky) |
| rx_nonempty | output | 1 | Receive data present (sticky) |
| rx_full | output | 1 | Four bytes received (sticky) |
| irq | output | 1 | Interrupt line |
| busy | output | 1 | Sequencer is running a burst or halt |

## Verification
The assertions assume a well-behaved bus agent. It raises bus_ack for exactly one cycle, only while bus_req is high. It drives bus_nack and bus_rdata only during that cycle. It keeps mst_addr and tx_bytes steady while busy is high. The bench's agent model follows these rules. It answers each request after a random delay of zero to two cycles and lowers bus_ack in the cycle after it answers. Stimulus changes mst_addr, tx_bytes and the interrupt enables only between operations, never while busy is high.

// File: rtl/i2cseq_pkg.sv
// Package: shared encodings for the I2C master transfer sequencer.
// Assumes the control byte layout is fixed; the byte count field is two bits.
package i2cseq_pkg;
    // Control byte bit positions (software-visible encoding).
    localparam int CTL_GO     = 0;
    localparam int CTL_RD     = 1;
    localparam int CTL_CHAIN  = 2;
    localparam int CTL_RSTART = 3;
    localparam int CTL_CNT_LSB = 4;
    localparam int CTL_ADDR10 = 6;
    localparam int CTL_HALT   = 7;

    // Command codes toward the byte-level bus agent.
    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_SEND  = 2'd1,
        CMD_RECV  = 2'd2,
        CMD_STOP  = 2'd3
    } bus_cmd_e;

    // Engine states.
    typedef enum logic [2:0] {
        E_IDLE  = 3'd0,
        E_START = 3'd1,
        E_XFER  = 3'd2,
        E_STOP  = 3'd3,
        E_HALT  = 3'd4
    } eng_state_e;
endpackage

// File: rtl/i2cseq_engine.sv
// Module: burst engine. It walks the bytes of one burst and issues one bus
// command at a time, holding each command until the agent acknowledges it.
// It tracks whether the bus is held, keeps err/aborted up to date, and pulses
// done (with the completed count) or halt_done when it returns to idle.
// Assumes: go and halt_go come only while idle; bus_ack is a one-cycle pulse.
module i2cseq_engine
    import i2cseq_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 7,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        go,
    input  logic                        halt_go,
    input  logic                        rd,
    input  logic                        chain,
    input  logic                        rstart,
    input  logic [IDX_W-1:0]            last_idx,
    input  logic [ADDR_W-1:0]           slave_addr,
    input  logic [MAX_BYTES*DATA_W-1:0] tx_bytes,
    input  logic                        bus_ack,
    input  logic                        bus_nack,
    output logic                        bus_req,
    output logic [1:0]                  bus_cmd,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        bus_read,
    output logic [DATA_W-1:0]           bus_wdata,
    output logic                        rx_wr,
    output logic [IDX_W-1:0]            rx_idx,
    output logic                        done,
    output logic                        halt_done,
    output logic [CNT_W-1:0]            done_cnt,
    output logic                        err,
    output logic                        aborted,
    output logic                        held,
    output logic                        busy
);
    eng_state_e          state;
    logic [IDX_W-1:0]    idx;
    logic [CNT_W-1:0]    cnt;
    logic [DATA_W-1:0]   tx_lane [MAX_BYTES];
    logic                last;
    bus_cmd_e            cmd;

    // Split the flat transmit vector into byte lanes.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_tx_lane
        assign tx_lane[g] = tx_bytes[g*DATA_W +: DATA_W];
    end

    assign last = (idx == last_idx);

    // Select the command for the current state.
    always_comb begin
        case (state)
            E_START: cmd = CMD_START;
            E_XFER:  cmd = rd ? CMD_RECV : CMD_SEND;
            default: cmd = CMD_STOP;
        endcase
    end

    assign bus_req   = (state != E_IDLE);
    assign bus_cmd   = cmd;
    assign bus_addr  = slave_addr;
    assign bus_read  = rd;
    assign bus_wdata = tx_lane[idx];
    assign rx_wr     = (state == E_XFER) && bus_ack && !bus_nack && rd;
    assign rx_idx    = idx;
    assign done_cnt  = cnt;
    assign busy      = (state != E_IDLE);

    // Burst state machine: byte index, completed count, bus hold and status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= E_IDLE;
            idx       <= '0;
            cnt       <= '0;
            held      <= 1'b0;
            err       <= 1'b0;
            aborted   <= 1'b0;
            done      <= 1'b0;
            halt_done <= 1'b0;
        end else begin
            done      <= 1'b0;
            halt_done <= 1'b0;
            case (state)
                E_IDLE: begin
                    if (go) begin
                        idx   <= '0;
                        cnt   <= '0;
                        state <= held ? E_XFER : E_START;
                    end else if (halt_go) begin
                        state <= E_HALT;
                    end
                end
                E_START: begin
                    if (bus_ack) begin
                        if (bus_nack) begin
                            err     <= 1'b1;
                            aborted <= 1'b1;
                            done    <= 1'b1;
                            state   <= E_IDLE;
                        end else begin
                            err   <= 1'b0;
                            held  <= 1'b1;
                            state <= E_XFER;
                        end
                    end
                end
                E_XFER: begin
                    if (bus_ack) begin
                        if (bus_nack) begin
                            err     <= 1'b1;
                            aborted <= 1'b1;
                            done    <= 1'b1;
                            state   <= E_IDLE;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                            if (rstart || !chain) begin
                                state <= E_STOP;
                            end else if (last) begin
                                done  <= 1'b1;
                                state <= E_IDLE;
                            end else begin
                                idx <= idx + IDX_W'(1);
                            end
                        end
                    end
                end
                E_STOP: begin
                    if (bus_ack) begin
                        held <= 1'b0;
                        if (last) begin
                            done  <= 1'b1;
                            state <= E_IDLE;
                        end else begin
                            idx   <= idx + IDX_W'(1);
                            state <= E_START;
                        end
                    end
                end
                E_HALT: begin
                    if (bus_ack) begin
                        held      <= 1'b0;
                        halt_done <= 1'b1;
                        state     <= E_IDLE;
                    end
                end
                default: state <= E_IDLE;
            endcase
        end
    end

    // R11
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd) && $stable(bus_wdata)));
    // R4
    start_only_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_cmd == CMD_START) |-> !held);
    // R5
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aborted) |-> $past(bus_ack && bus_nack));
    // R6
    release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(held) |-> $past(bus_ack && bus_cmd == CMD_STOP));
endmodule

// File: rtl/i2cseq_rxstore.sv
// Module: receive lanes. It writes one byte into lane rx_idx on each strobe.
// Lanes keep their contents until they are overwritten; reset clears them.
// Assumes: rx_idx < MAX_BYTES whenever rx_wr is high.
module i2cseq_rxstore #(
    parameter int MAX_BYTES = 4,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(MAX_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_wr,
    input  logic [IDX_W-1:0]            rx_idx,
    input  logic [DATA_W-1:0]           rx_data,
    output logic [MAX_BYTES*DATA_W-1:0] rx_bytes
);
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        // Capture a received byte in this lane when it is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                rx_bytes[g*DATA_W +: DATA_W] <= '0;
            else if (rx_wr && rx_idx == IDX_W'(g))
                rx_bytes[g*DATA_W +: DATA_W] <= rx_data;
        end
    end
endmodule

// File: rtl/i2cseq_status.sv
// Module: control byte register and completion bookkeeping. It accepts a
// control write only while idle, decodes start and halt, and on burst end it
// records the completed count, the read flags and the interrupt.
// Assumes: done/halt_done are one-cycle pulses from the engine.
module i2cseq_status
    import i2cseq_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [7:0]       ctrl_wdata,
    input  logic             busy,
    input  logic             held,
    input  logic             done,
    input  logic             halt_done,
    input  logic [CNT_W-1:0] done_cnt,
    input  logic             int_en,
    input  logic             mask_done,
    input  logic             mask_halt,
    input  logic             irq_ack,
    output logic [7:0]       ctrl_q,
    output logic             go,
    output logic             halt_go,
    output logic [CNT_W-1:0] xfer_count,
    output logic [CNT_W-1:0] buf_idx,
    output logic             rx_nonempty,
    output logic             rx_full,
    output logic             irq
);
    logic accept;
    logic irq_set;

    assign accept  = ctrl_wr && !busy;
    assign halt_go = accept && ctrl_wdata[CTL_HALT] && held;
    assign go      = accept && ctrl_wdata[CTL_GO] && !halt_go;
    assign irq_set = (done && done_cnt != '0 && int_en && mask_done)
                   || (halt_done && int_en && mask_halt);

    // Store the control byte without its self-clearing start bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl_q <= '0;
        else if (accept) ctrl_q <= ctrl_wdata & 8'hFE;
    end

    // Record the count and read flags when a burst ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xfer_count  <= '0;
            buf_idx     <= '1;
            rx_nonempty <= 1'b0;
            rx_full     <= 1'b0;
        end else if (done) begin
            xfer_count <= done_cnt;
            buf_idx    <= done_cnt - CNT_W'(1);
            if (ctrl_q[CTL_RD] && done_cnt != '0)
                rx_nonempty <= 1'b1;
            if (ctrl_q[CTL_RD] && done_cnt == CNT_W'(MAX_BYTES))
                rx_full <= 1'b1;
        end
    end

    // Interrupt line: set by events, cleared by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_set) irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    // R2
    busy_write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && ctrl_wr) |=> $stable(ctrl_q));
    // R8
    full_implies_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> rx_nonempty);
    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(int_en));
    // R7
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_count <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/i2cseq_top.sv
// Module: top of the I2C master transfer sequencer. Wires the control and
// status logic, the burst engine and the receive lanes together.
// Assumes: mst_addr and tx_bytes stay steady while busy is high.
module i2cseq_top
    import i2cseq_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int DATA_W    = 8,
    localparam int ADDR_W   = 7,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ctrl_wr,
    input  logic [7:0]                  ctrl_wdata,
    input  logic [7:0]                  mst_addr,
    input  logic [MAX_BYTES*DATA_W-1:0] tx_bytes,
    input  logic                        int_en,
    input  logic                        mask_done,
    input  logic                        mask_halt,
    input  logic                        irq_ack,
    output logic                        bus_req,
    output logic [1:0]                  bus_cmd,
    output logic [ADDR_W-1:0]           bus_addr,
    output logic                        bus_read,
    output logic [DATA_W-1:0]           bus_wdata,
    input  logic                        bus_ack,
    input  logic                        bus_nack,
    input  logic [DATA_W-1:0]           bus_rdata,
    output logic [7:0]                  ctrl_q,
    output logic [CNT_W-1:0]            xfer_count,
    output logic [CNT_W-1:0]            buf_idx,
    output logic [MAX_BYTES*DATA_W-1:0] rx_bytes,
    output logic                        err,
    output logic                        aborted,
    output logic                        rx_nonempty,
    output logic                        rx_full,
    output logic                        irq,
    output logic                        busy
);
    logic             go, halt_go, held, done, halt_done, rx_wr;
    logic [CNT_W-1:0] done_cnt;
    logic [IDX_W-1:0] rx_idx;
    logic             unused_addr_lsb;

    assign unused_addr_lsb = mst_addr[0];

    i2cseq_status #(.MAX_BYTES(MAX_BYTES)) u_status (
        .clk(clk), .rst_n(rst_n),
        .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .busy(busy), .held(held), .done(done), .halt_done(halt_done),
        .done_cnt(done_cnt), .int_en(int_en), .mask_done(mask_done),
        .mask_halt(mask_halt), .irq_ack(irq_ack),
        .ctrl_q(ctrl_q), .go(go), .halt_go(halt_go),
        .xfer_count(xfer_count), .buf_idx(buf_idx),
        .rx_nonempty(rx_nonempty), .rx_full(rx_full), .irq(irq)
    );

    i2cseq_engine #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
        .clk(clk), .rst_n(rst_n),
        .go(go), .halt_go(halt_go),
        .rd(ctrl_q[CTL_RD]), .chain(ctrl_q[CTL_CHAIN]), .rstart(ctrl_q[CTL_RSTART]),
        .last_idx(ctrl_q[CTL_CNT_LSB +: IDX_W]),
        .slave_addr(mst_addr[7:1]), .tx_bytes(tx_bytes),
        .bus_ack(bus_ack), .bus_nack(bus_nack),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_read(bus_read), .bus_wdata(bus_wdata),
        .rx_wr(rx_wr), .rx_idx(rx_idx),
        .done(done), .halt_done(halt_done), .done_cnt(done_cnt),
        .err(err), .aborted(aborted), .held(held), .busy(busy)
    );

    i2cseq_rxstore #(.MAX_BYTES(MAX_BYTES), .DATA_W(DATA_W)) u_rxstore (
        .clk(clk), .rst_n(rst_n),
        .rx_wr(rx_wr), .rx_idx(rx_idx), .rx_data(bus_rdata),
        .rx_bytes(rx_bytes)
    );
endmodule

// File: tb/i2cseq_top_tb_top.sv
// Bench: seeded random control bytes mixed with directed corner cases. A
// behavioural bus agent answers commands; expectations come from a model task.
module i2cseq_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic [7:0]  mst_addr = 8'hA4;
    logic [31:0] tx_bytes = 32'h44332211;
    logic        int_en = 1'b0, mask_done = 1'b0, mask_halt = 1'b0, irq_ack = 1'b0;
    logic        bus_req, bus_read;
    logic [1:0]  bus_cmd;
    logic [6:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_ack = 1'b0, bus_nack = 1'b0;
    logic [7:0]  bus_rdata = '0;
    logic [7:0]  ctrl_q;
    logic [2:0]  xfer_count, buf_idx;
    logic [31:0] rx_bytes;
    logic        err, aborted, rx_nonempty, rx_full, irq, busy;

    i2cseq_top dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .mst_addr(mst_addr), .tx_bytes(tx_bytes), .int_en(int_en),
        .mask_done(mask_done), .mask_halt(mask_halt), .irq_ack(irq_ack),
        .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
        .bus_read(bus_read), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_nack(bus_nack), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q),
        .xfer_count(xfer_count), .buf_idx(buf_idx), .rx_bytes(rx_bytes),
        .err(err), .aborted(aborted), .rx_nonempty(rx_nonempty),
        .rx_full(rx_full), .irq(irq), .busy(busy)
    );

    // 125 MHz: 8 time units per period, taken as ns.
    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cycles = 0;
    // Agent configuration and observations.
    bit  ag_addr_nack = 0;
    int  ag_nack_at = -1, ag_dcnt = 0, ag_starts = 0, ag_stops = 0, ag_wmis = 0, ag_wait = 0;
    logic [6:0] ag_addr = '0;
    logic [7:0] rx_seed = '0;
    // Model state.
    bit m_held = 0, m_err = 0, m_ab = 0, m_ne = 0, m_full = 0, m_irq = 0;
    int m_cnt = 0;
    logic [7:0] m_ctrl = '0;
    logic [7:0] exp_rx [4];

    function automatic logic [7:0] pat(input int i);
        return 8'(int'(rx_seed) + 29 * i + 7);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
                report();
            end
        end
    end

    // Bus agent: answers after 0..2 cycles, one-cycle ack, checks send data.
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 0; bus_nack = 0;
            end else if (rst_n && bus_req) begin
                if (ag_wait > 0) ag_wait--;
                else begin
                    case (bus_cmd)
                        2'd0: begin ag_starts++; ag_addr = bus_addr; bus_nack = ag_addr_nack; end
                        2'd1: begin
                            if (bus_wdata !== tx_bytes[ag_dcnt*8 +: 8]) ag_wmis++;
                            bus_nack = (ag_dcnt == ag_nack_at); ag_dcnt++;
                        end
                        2'd2: begin bus_rdata = pat(ag_dcnt); bus_nack = (ag_dcnt == ag_nack_at); ag_dcnt++; end
                        default: begin ag_stops++; bus_nack = 0; end
                    endcase
                    bus_ack = 1;
                    ag_wait = $urandom % 3;
                end
            end
        end
    end

    // One control write: model the outcome, drive it, wait, check the ports.
    task automatic run_ctrl(input logic [7:0] v, input bit anack, input int nat, input bit wr_busy);
        int starts = 0, stops = 0, c = 0, guard = 0;
        bit op = 0, rd, chain, rps;
        rd = v[1]; chain = v[2]; rps = v[3];
        ag_addr_nack = anack; ag_nack_at = nat; ag_dcnt = 0;
        ag_starts = 0; ag_stops = 0; ag_wmis = 0; rx_seed = 8'($urandom);
        irq_ack = 1; @(negedge clk); irq_ack = 0; m_irq = 0;
        m_ctrl = v & 8'hFE;
        if (v[7] && m_held) begin
            op = 1; stops = 1; m_held = 0;
            if (int_en && mask_halt) m_irq = 1;
        end else if (v[0]) begin
            op = 1;
            for (int i = 0; i <= int'(v[5:4]); i++) begin
                if (!m_held) begin
                    starts++;
                    if (anack) begin m_err = 1; m_ab = 1; break; end
                    m_err = 0; m_held = 1;
                end
                if (nat == i) begin m_err = 1; m_ab = 1; break; end
                if (rd) exp_rx[i] = pat(i);
                c++;
                if (rps || !chain) begin stops++; m_held = 0; end
            end
            m_cnt = c;
            if (rd && c > 0) m_ne = 1;
            if (rd && c == 4) m_full = 1;
            if (c > 0 && int_en && mask_done) m_irq = 1;
        end
        ctrl_wdata = v; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0;
        if (wr_busy) begin
            // R2: this write arrives while busy and must be dropped.
            ctrl_wdata = 8'h3B; ctrl_wr = 1; @(negedge clk); ctrl_wr = 0;
        end
        if (op) begin
            while (busy && guard < 2000) begin @(negedge clk); guard++; end
            @(negedge clk);
        end else repeat (3) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(busy == 0 && bus_req == 0, "R2 idle after op", {30'd0, busy, bus_req}, 0);
        chk(ctrl_q == m_ctrl, "R2 ctrl_q", ctrl_q, m_ctrl);
        chk(ag_starts == starts, "R4 start count", ag_starts, starts);
        chk(ag_stops == stops, "R6 stop count", ag_stops, stops);
        if (starts > 0) chk(ag_addr == mst_addr[7:1], "R3 slave address", ag_addr, mst_addr[7:1]);
        chk(ag_wmis == 0, "R8 send data", ag_wmis, 0);
        chk(err == m_err, "R4 R5 err", err, m_err);
        chk(aborted == m_ab, "R5 aborted", aborted, m_ab);
        chk(xfer_count == 3'(m_cnt), "R7 xfer_count", xfer_count, m_cnt);
        chk(buf_idx == 3'(m_cnt - 1), "R7 buf_idx", buf_idx, 3'(m_cnt - 1));
        chk(rx_nonempty == m_ne, "R8 rx_nonempty", rx_nonempty, m_ne);
        chk(rx_full == m_full, "R8 rx_full", rx_full, m_full);
        chk(irq == m_irq, "R9 R10 irq", irq, m_irq);
        for (int i = 0; i < 4; i++)
            chk(rx_bytes[i*8 +: 8] == exp_rx[i], "R8 rx lane", rx_bytes[i*8 +: 8], exp_rx[i]);
    endtask

    initial begin
        void'($urandom(32'h1C2A));
        for (int i = 0; i < 4; i++) exp_rx[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ctrl_q == 0 && xfer_count == 0 && buf_idx == 3'b111, "R1 regs",
            {13'd0, ctrl_q, xfer_count, buf_idx}, 32'h7);
        chk({err, aborted, rx_nonempty, rx_full, irq, busy, bus_req} == 0, "R1 flags",
            {err, aborted, rx_nonempty, rx_full, irq, busy, bus_req}, 0);
        rst_n = 1; @(negedge clk);
        int_en = 1; mask_done = 1; mask_halt = 1;
        // R6 R8 R10: four-byte write, stop after each byte
        run_ctrl(8'h31, 0, -1, 0);
        // R6 R8: four-byte chained read keeps the bus held, fills lanes
        run_ctrl(8'h37, 0, -1, 0);
        // R9: halt with start bit while held -> one stop only
        run_ctrl(8'h81, 0, -1, 0);
        // R4 R10: address nack, no completion irq
        run_ctrl(8'h01, 1, -1, 0);
        // R4: successful address clears err; R6 repeated start forces stops
        run_ctrl(8'h1F, 0, -1, 0);
        // R5: data nack on third byte leaves bus held
        run_ctrl(8'h31, 0, 2, 0);
        // R9: halt frees it; no irq with mask_halt low
        mask_halt = 0;
        run_ctrl(8'h80, 0, -1, 0);
        // R9: halt while free, start clear -> nothing
        run_ctrl(8'h80, 0, -1, 0);
        // R2: write while busy dropped
        run_ctrl(8'h11, 0, -1, 1);
        // R3: ten-bit request ignored
        mst_addr = 8'hA5;
        run_ctrl(8'h41, 0, -1, 0);
        // R12: irq_ack clears irq
        irq_ack = 1; @(negedge clk); irq_ack = 0; @(negedge clk);
        chk(irq == 0, "R12 irq_ack", irq, 0);
        // R11 and mixed behaviour under seeded random control bytes
        for (int n = 0; n < 40; n++) begin
            logic [7:0] v;
            int nat;
            v = {1'b0, 7'($urandom)} | 8'h01;
            nat = ($urandom % 4 == 0) ? int'($urandom % 4) : -1;
            mst_addr = 8'($urandom); tx_bytes = $urandom;
            int_en = 1'($urandom); mask_done = 1'($urandom); mask_halt = 1'($urandom);
            run_ctrl(v, ($urandom % 8 == 0), nat, 0);
        end
        report();
    end
endmodule